// File: doc/BRIEF.md
# Trap Delegation CSR Bank

This bank holds the machine-level registers that decide which interrupts are enabled, which are pending, and which interrupts and exceptions are handed down to supervisor mode. It also holds the trap-vector base registers for machine and supervisor mode. A core drives one CSR access at a time through an address, a write-data word and a write enable. Reads are combinational and return the selected register in the same cycle. A write takes effect at the next rising clock edge.

The supervisor enable and pending registers have no storage of their own. Each is a view of the matching machine register, restricted by the interrupt-delegation mask. The machine timer, software and external interrupt lines come straight from outside and show up in the pending view. Every register has its own fixed set of writable bits, and all other bits read as zero. The stored values are also driven out on ports, so that trap-entry logic can consume them.

Interrupt bit positions: supervisor software = 1, machine software = 3, supervisor timer = 5, machine timer = 7, supervisor external = 9, machine external = 11.

Top module: `trap_csr_bank`

## Requirements
- R1: After reset all stored registers are zero. Every address reads zero, except that the machine pending view still shows the external lines.
- R2: The machine pending view at 0x344 shows bit 3 = software line, bit 7 = timer line and bit 11 = external line, following the inputs in the same cycle. A write to 0x344 can change only bits 1 and 5.
- R3: The machine enable register at 0x304 stores only bits 1, 3, 5, 7 and 9 of a write. Every other bit reads zero.
- R4: The interrupt-delegation register at 0x303 stores only bits 1, 5 and 9. It holds its value in every cycle it is not written.
- R5: The exception-delegation register at 0x302 stores bits 0 to 13 and bit 15. Bit 14 and all bits above 15 read zero.
- R6: A read of the supervisor pending view at 0x144 returns the machine pending view ANDed with the delegation mask. A write to 0x144 changes only bits that are both delegated and among bits 1 and 5.
- R7: A read of the supervisor enable view at 0x104 returns the machine enable register ANDed with the delegation mask. A write to 0x104 changes only delegated bits.
- R8: A write to the machine vector at 0x305 or the supervisor vector at 0x105 whose bits [1:0] are 00 stores the word. A write with any other value in bits [1:0] leaves the register unchanged.
- R9: An address outside the eight listed reads zero, and a write to it changes no register.
- R10: A write is visible on the read port and on the state outputs from the first cycle after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csrAddr | input | 12 | CSR address for the read and the write |
| csrWdata | input | XLEN | Write data |
| csrWe | input | 1 | Write enable |
| csrRdata | output | XLEN | Combinational read data for csrAddr |
| extSoftIrq | input | 1 | Machine software interrupt line |
| extTimerIrq | input | 1 | Machine timer interrupt line |
| extExtIrq | input | 1 | Machine external interrupt line |
| intEnable | output | XLEN | Machine enable register |
| intPending | output | XLEN | Machine pending view, including the external lines |
| intDeleg | output | XLEN | Interrupt-delegation mask |
| excDeleg | output | XLEN | Exception-delegation mask |
| mVector | output | XLEN | Machine trap-vector base |
| sVector | output | XLEN | Supervisor trap-vector base |

## Verification
The bench builds the bank with XLEN = 32, which is the default. With that width, all-ones writes reach every unwritable bit, including the upper half, and exception cause 14 and the bits above 15 can be checked as staying zero. The 12-bit address lets the bench place an unused address (0x345) right next to the decoded ones. The three external lines are driven in several combinations, which puts live pending bits under the delegation mask in the supervisor views.

// File: rtl/trap_csr_pkg.sv
package trap_csr_pkg;

  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] ADR_MEDELEG = 12'h302;
  localparam logic [ADDR_W-1:0] ADR_MIDELEG = 12'h303;
  localparam logic [ADDR_W-1:0] ADR_MIE     = 12'h304;
  localparam logic [ADDR_W-1:0] ADR_MTVEC   = 12'h305;
  localparam logic [ADDR_W-1:0] ADR_MIP     = 12'h344;
  localparam logic [ADDR_W-1:0] ADR_SIE     = 12'h104;
  localparam logic [ADDR_W-1:0] ADR_STVEC   = 12'h105;
  localparam logic [ADDR_W-1:0] ADR_SIP     = 12'h144;

  localparam int BIT_SSW = 1;
  localparam int BIT_MSW = 3;
  localparam int BIT_STM = 5;
  localparam int BIT_MTM = 7;
  localparam int BIT_SEX = 9;
  localparam int BIT_MEX = 11;

  localparam int NUM_CAUSE      = 16;
  localparam int RESERVED_CAUSE = 14;
  localparam int NUM_VEC        = 2;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MIE, SEL_MIP, SEL_MIDELEG, SEL_MEDELEG,
    SEL_MTVEC, SEL_STVEC, SEL_SIE, SEL_SIP
  } rdSel_e;

  typedef struct packed {
    logic   wrMie;
    logic   wrMip;
    logic   wrMideleg;
    logic   wrMedeleg;
    logic   wrMtvec;
    logic   wrStvec;
    logic   wrSie;
    logic   wrSip;
    rdSel_e rdSel;
  } csrStrobe_t;

  function automatic logic [63:0] bitAt(input int pos);
    return 64'(1) << pos;
  endfunction

  function automatic logic [63:0] causeMask();
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < NUM_CAUSE; i++) begin
      if (i != RESERVED_CAUSE) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/trap_csr_ctrl.sv
module trap_csr_ctrl
  import trap_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              csrWe,
  output csrStrobe_t        strb
);

  rdSel_e sel;

  always_comb begin
    unique case (csrAddr)
      ADR_MIE:     sel = SEL_MIE;
      ADR_MIP:     sel = SEL_MIP;
      ADR_MIDELEG: sel = SEL_MIDELEG;
      ADR_MEDELEG: sel = SEL_MEDELEG;
      ADR_MTVEC:   sel = SEL_MTVEC;
      ADR_STVEC:   sel = SEL_STVEC;
      ADR_SIE:     sel = SEL_SIE;
      ADR_SIP:     sel = SEL_SIP;
      default:     sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strb           = '0;
    strb.rdSel     = sel;
    strb.wrMie     = csrWe && (sel == SEL_MIE);
    strb.wrMip     = csrWe && (sel == SEL_MIP);
    strb.wrMideleg = csrWe && (sel == SEL_MIDELEG);
    strb.wrMedeleg = csrWe && (sel == SEL_MEDELEG);
    strb.wrMtvec   = csrWe && (sel == SEL_MTVEC);
    strb.wrStvec   = csrWe && (sel == SEL_STVEC);
    strb.wrSie     = csrWe && (sel == SEL_SIE);
    strb.wrSip     = csrWe && (sel == SEL_SIP);
  end

  // R9: at most one register is written per access, and none for an unknown address
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.wrMie, strb.wrMip, strb.wrMideleg, strb.wrMedeleg,
              strb.wrMtvec, strb.wrStvec, strb.wrSie, strb.wrSip}));
  a_r9_unknown_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rdSel == SEL_NONE) |->
      ($countones({strb.wrMie, strb.wrMip, strb.wrMideleg, strb.wrMedeleg,
                   strb.wrMtvec, strb.wrStvec, strb.wrSie, strb.wrSip}) == 0));

endmodule

// File: rtl/trap_csr_dp.sv
module trap_csr_dp
  import trap_csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  csrStrobe_t      strb,
  input  logic [XLEN-1:0] wdata,
  input  logic            extSoftIrq,
  input  logic            extTimerIrq,
  input  logic            extExtIrq,
  output logic [XLEN-1:0] rdata,
  output logic [XLEN-1:0] mieQ,
  output logic [XLEN-1:0] mipView,
  output logic [XLEN-1:0] midelegQ,
  output logic [XLEN-1:0] medelegQ,
  output logic [XLEN-1:0] mtvecQ,
  output logic [XLEN-1:0] stvecQ
);

  localparam logic [XLEN-1:0] MIE_WMASK = XLEN'(bitAt(BIT_SSW) | bitAt(BIT_MSW) |
                                                bitAt(BIT_STM) | bitAt(BIT_MTM) |
                                                bitAt(BIT_SEX));
  localparam logic [XLEN-1:0] MIP_WMASK = XLEN'(bitAt(BIT_SSW) | bitAt(BIT_STM));
  localparam logic [XLEN-1:0] DLG_WMASK = XLEN'(bitAt(BIT_SSW) | bitAt(BIT_STM) |
                                                bitAt(BIT_SEX));
  localparam logic [XLEN-1:0] EXC_WMASK = XLEN'(causeMask());

  logic [XLEN-1:0] mipSwQ;
  logic [XLEN-1:0] mipSrc, mieSrc;
  logic [XLEN-1:0] vecQ [NUM_VEC];

  always_comb begin
    mipView          = mipSwQ;
    mipView[BIT_MSW] = extSoftIrq;
    mipView[BIT_MTM] = extTimerIrq;
    mipView[BIT_MEX] = extExtIrq;
  end

  // supervisor writes merge into the machine value under the delegation mask
  always_comb begin
    mipSrc = strb.wrSip ? ((mipView & ~midelegQ) | (wdata & midelegQ)) : wdata;
    mieSrc = strb.wrSie ? ((mieQ & ~midelegQ) | (wdata & midelegQ)) : wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mieQ     <= '0;
      mipSwQ   <= '0;
      midelegQ <= '0;
      medelegQ <= '0;
    end else begin
      if (strb.wrMie || strb.wrSie)
        mieQ <= (mieQ & ~MIE_WMASK) | (mieSrc & MIE_WMASK);
      if (strb.wrMip || strb.wrSip)
        mipSwQ <= (mipSwQ & ~MIP_WMASK) | (mipSrc & MIP_WMASK);
      if (strb.wrMideleg)
        midelegQ <= wdata & DLG_WMASK;
      if (strb.wrMedeleg)
        medelegQ <= wdata & EXC_WMASK;
    end
  end

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
    logic wrVec;
    assign wrVec = (g == 0) ? strb.wrMtvec : strb.wrStvec;

    always_ff @(posedge clk) begin
      if (!rst_n)
        vecQ[g] <= '0;
      else if (wrVec && (wdata[1:0] == 2'b00))
        vecQ[g] <= {wdata[XLEN-1:2], 2'b00};
    end

    // R8: a write with a non-direct mode value leaves the vector untouched
    a_r8_vector_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wrVec && (wdata[1:0] != 2'b00)) |=> $stable(vecQ[g]));
  end

  assign mtvecQ = vecQ[0];
  assign stvecQ = vecQ[1];

  always_comb begin
    unique case (strb.rdSel)
      SEL_MIE:     rdata = mieQ;
      SEL_MIP:     rdata = mipView;
      SEL_MIDELEG: rdata = midelegQ;
      SEL_MEDELEG: rdata = medelegQ;
      SEL_MTVEC:   rdata = mtvecQ;
      SEL_STVEC:   rdata = stvecQ;
      SEL_SIE:     rdata = mieQ & midelegQ;
      SEL_SIP:     rdata = mipView & midelegQ;
      default:     rdata = '0;
    endcase
  end

  // R4: the delegation mask changes only on its own write
  a_r4_deleg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wrMideleg |=> $stable(midelegQ));

  // R6: a supervisor pending write leaves undelegated software bits alone
  a_r6_sip_keeps_undelegated: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrSip |=> ((mipSwQ & ~$past(midelegQ)) == ($past(mipSwQ) & ~$past(midelegQ))));

  // R7: a supervisor enable write leaves undelegated enable bits alone
  a_r7_sie_keeps_undelegated: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrSie |=> ((mieQ & ~$past(midelegQ)) == ($past(mieQ) & ~$past(midelegQ))));

  // R2: the machine lines reach the pending view unregistered
  a_r2_lines_live: assert property (@(posedge clk) disable iff (!rst_n)
    (mipView[BIT_MTM] == extTimerIrq) && (mipView[BIT_MSW] == extSoftIrq) &&
    (mipView[BIT_MEX] == extExtIrq));

endmodule

// File: rtl/trap_csr_bank.sv
module trap_csr_bank
  import trap_csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [XLEN-1:0]   csrWdata,
  input  logic              csrWe,
  output logic [XLEN-1:0]   csrRdata,
  input  logic              extSoftIrq,
  input  logic              extTimerIrq,
  input  logic              extExtIrq,
  output logic [XLEN-1:0]   intEnable,
  output logic [XLEN-1:0]   intPending,
  output logic [XLEN-1:0]   intDeleg,
  output logic [XLEN-1:0]   excDeleg,
  output logic [XLEN-1:0]   mVector,
  output logic [XLEN-1:0]   sVector
);

  csrStrobe_t strb;

  trap_csr_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .csrAddr (csrAddr),
    .csrWe   (csrWe),
    .strb    (strb)
  );

  trap_csr_dp #(.XLEN(XLEN)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .wdata       (csrWdata),
    .extSoftIrq  (extSoftIrq),
    .extTimerIrq (extTimerIrq),
    .extExtIrq   (extExtIrq),
    .rdata       (csrRdata),
    .mieQ        (intEnable),
    .mipView     (intPending),
    .midelegQ    (intDeleg),
    .medelegQ    (excDeleg),
    .mtvecQ      (mVector),
    .stvecQ      (sVector)
  );

endmodule

// File: tb/trap_csr_bank_tb.sv
module trap_csr_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [31:0] csrWdata = '0;
  logic        csrWe = 1'b0;
  logic [31:0] csrRdata;
  logic        extSoftIrq = 1'b0, extTimerIrq = 1'b0, extExtIrq = 1'b0;
  logic [31:0] intEnable, intPending, intDeleg, excDeleg, mVector, sVector;

  int checkCount = 0;
  int failCount  = 0;
  bit done       = 1'b0;

  // reference state
  logic [31:0] mMie = '0, mSw = '0, mDeleg = '0, mMed = '0, mMtvec = '0, mStvec = '0;

  always #5 clk = ~clk;

  trap_csr_bank #(.XLEN(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .csrAddr(csrAddr), .csrWdata(csrWdata), .csrWe(csrWe),
    .csrRdata(csrRdata), .extSoftIrq(extSoftIrq), .extTimerIrq(extTimerIrq),
    .extExtIrq(extExtIrq), .intEnable(intEnable), .intPending(intPending),
    .intDeleg(intDeleg), .excDeleg(excDeleg), .mVector(mVector), .sVector(sVector)
  );

  function automatic logic [31:0] pendView();
    logic [31:0] v;
    v = mSw;
    if (extSoftIrq)  v = v | 32'h008;
    if (extTimerIrq) v = v | 32'h080;
    if (extExtIrq)   v = v | 32'h800;
    return v;
  endfunction

  function automatic logic [31:0] expRead(input logic [11:0] a);
    case (a)
      12'h304: return mMie;
      12'h344: return pendView();
      12'h303: return mDeleg;
      12'h302: return mMed;
      12'h305: return mMtvec;
      12'h105: return mStvec;
      12'h104: return mMie & mDeleg;
      12'h144: return pendView() & mDeleg;
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelWrite(input logic [11:0] a, input logic [31:0] d);
    case (a)
      12'h304: mMie = d & 32'h2AA;
      12'h344: mSw = d & 32'h22;
      12'h303: mDeleg = d & 32'h222;
      12'h302: mMed = d & 32'hBFFF;
      12'h305: if (d[1:0] == 2'b00) mMtvec = d;
      12'h105: if (d[1:0] == 2'b00) mStvec = d;
      12'h104: mMie = (mMie & ~mDeleg) | (d & mDeleg & 32'h2AA);
      12'h144: mSw = (mSw & ~mDeleg) | (d & mDeleg & 32'h22);
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one access: drive, check the read port and the state outputs, clock, update model
  task automatic step(input logic [11:0] a, input logic [31:0] d, input logic we,
                      input logic [2:0] ext, input string tag);
    csrAddr = a; csrWdata = d; csrWe = we;
    {extExtIrq, extTimerIrq, extSoftIrq} = ext;
    #1;
    check(tag, $sformatf("read %h", a), csrRdata, expRead(a));
    check(tag, "state", {intEnable ^ mMie ^ intDeleg ^ mDeleg ^ excDeleg ^ mMed},
          32'h0);
    check(tag, "vectors/pending", {mVector ^ mMtvec ^ sVector ^ mStvec ^
                                   intPending ^ pendView()}, 32'h0);
    @(posedge clk);
    if (we) modelWrite(a, d);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checkCount++; failCount++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    logic [11:0] addrs [9];
    addrs = '{12'h304, 12'h344, 12'h303, 12'h302, 12'h305, 12'h105, 12'h104,
              12'h144, 12'h345};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    step(12'h304, 0, 0, 3'b000, "R1");
    step(12'h303, 0, 0, 3'b000, "R1");
    step(12'h302, 0, 0, 3'b000, "R1");
    step(12'h305, 0, 0, 3'b000, "R1");
    step(12'h144, 0, 0, 3'b000, "R1");
    // R2: live lines in the pending view
    step(12'h344, 0, 0, 3'b001, "R2");
    step(12'h344, 0, 0, 3'b110, "R2");
    step(12'h344, 32'hFFFF_FFFF, 1, 3'b000, "R2");
    step(12'h344, 0, 0, 3'b111, "R2");
    // R3: enable mask
    step(12'h304, 32'hFFFF_FFFF, 1, 3'b000, "R3");
    step(12'h304, 0, 0, 3'b000, "R3");
    // R4: delegation mask
    step(12'h303, 32'hFFFF_FFFF, 1, 3'b000, "R4");
    step(12'h303, 0, 0, 3'b000, "R4");
    step(12'h303, 32'h0000_0002, 1, 3'b000, "R4");
    // R5: exception delegation, cause 14 stays zero
    step(12'h302, 32'hFFFF_FFFF, 1, 3'b000, "R5");
    step(12'h302, 0, 0, 3'b000, "R5");
    // R6: supervisor pending; only bit 1 delegated, bit 5 must survive
    step(12'h144, 0, 0, 3'b111, "R6");
    step(12'h144, 32'h0, 1, 3'b111, "R6");
    step(12'h344, 0, 0, 3'b000, "R6");
    step(12'h144, 32'hFFFF_FFFF, 1, 3'b000, "R6");
    step(12'h344, 0, 0, 3'b000, "R6");
    // R7: supervisor enable with bits 1 and 9 delegated
    step(12'h303, 32'h0000_0202, 1, 3'b000, "R7");
    step(12'h104, 32'h0, 1, 3'b000, "R7");
    step(12'h304, 0, 0, 3'b000, "R7");
    step(12'h104, 32'hFFFF_FFFF, 1, 3'b000, "R7");
    step(12'h104, 0, 0, 3'b000, "R7");
    // R8: vector mode handling
    step(12'h305, 32'h8000_1000, 1, 3'b000, "R8");
    step(12'h305, 32'h0000_2001, 1, 3'b000, "R8");
    step(12'h305, 32'h0000_3002, 1, 3'b000, "R8");
    step(12'h305, 32'h0000_4003, 1, 3'b000, "R8");
    step(12'h105, 32'h0000_0F00, 1, 3'b000, "R8");
    step(12'h105, 32'hFFFF_FFFD, 1, 3'b000, "R8");
    step(12'h105, 0, 0, 3'b000, "R8");
    // R9: unknown address
    step(12'h345, 32'hFFFF_FFFF, 1, 3'b111, "R9");
    step(12'h000, 32'hFFFF_FFFF, 1, 3'b000, "R9");
    step(12'h304, 0, 0, 3'b000, "R9");
    // R10: mixed traffic, each write checked on the next access
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(addrs[lfsr[7:4] % 9], {lfsr[15:0], lfsr[31:16]}, lfsr[8], lfsr[11:9], "R10");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule